// File: doc/BRIEF.md
# Generator Pause/Resume Controller

This controller stops a free-running random number source when the buffer that captures its output has filled. It starts the source again once the host has finished checking the captured data. It does not gate the enable directly. Instead it produces a 32-bit modification word that is combined by bitwise exclusive-or with the host's global enable word. While the word is zero, the effective enable equals the global enable. While it is all ones, every enable bit is inverted, and the source stops.

A four-state sequencer drives the word. The states are start-up, waiting for the buffer to fill, paused, and a single resume cycle. The host's check-done indication is captured into a sticky latch only while the sequencer is paused. The sequencer acknowledges and clears that latch when it moves into the resume cycle. After the first pass the sequencer cycles through waiting, paused and resume without returning to start-up.

Top module: `gen_pause_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, the modification word is 0x00000000. Reset also clears a check-done latch captured earlier, so a later pause lasts until a new check-done arrives.
- R2: The effective enable is the global enable with every bit inverted when the modification word is 0xFFFFFFFF. It equals the global enable when the word is 0x00000000. The word never takes any other value.
- R3: The start-up state lasts exactly one cycle after reset is released. A full flag sampled in that cycle is ignored.
- R4: In the waiting state the word is 0x00000000. A full flag sampled high there makes the word 0xFFFFFFFF from the next cycle on.
- R5: While paused with no captured check-done, the word stays 0xFFFFFFFF whatever the full flag does.
- R6: A check-done sampled high while paused sets the latch. On the following edge the sequencer acknowledges it and clears the latch. The word is therefore 0x00000000 two edges after the check-done sample.
- R7: The resume state lasts one cycle and is followed by the waiting state. A full flag sampled during the resume cycle is ignored.
- R8: A check-done sampled outside the paused state is not captured and does not shorten a later pause.
- R9: After the first pass the start-up state is never revisited without reset. A full flag sampled in the waiting state right after resume pauses the source again on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| buf_full_i | input | 1 | Capture buffer full flag from the write controller |
| host_done_i | input | 1 | Host indication that checking of the buffered data has finished |
| glob_en_i | input | 32 | Global enable word from the host |
| mod_word_o | output | 32 | Enable modification word (0x00000000 or 0xFFFFFFFF) |
| gen_en_o | output | 32 | Effective generator enable: global enable XOR modification word |

## Verification
A table of cycles walks two full pause/resume passes, each cycle with a different global enable pattern. This shows the inversion by the mask and rules out a fixed or partial mask. The full and check-done inputs are pulsed in every state. Early check-done pulses must not shorten the pause, full pulses in start-up and resume must not trigger one, and a full pulse held through the pause must not extend it. Directed runs assert reset in the middle of a pause after a check-done has been captured. A stale latch surviving reset would then end the next pause early.

// File: rtl/gen_pause_pkg.sv
package gen_pause_pkg;

    localparam int unsigned EN_W_DEF   = 32;
    localparam int unsigned LANE_W_DEF = 8;

    typedef enum logic [1:0] {
        ST_START  = 2'd0,
        ST_WAIT   = 2'd1,
        ST_PAUSE  = 2'd2,
        ST_RESUME = 2'd3
    } pause_st_e;

    typedef struct packed {
        logic capture_en;
        logic ack;
        logic pause;
    } seq_ctl_t;

    function automatic logic st_pauses(input pause_st_e st);
        return (st == ST_PAUSE);
    endfunction

    function automatic pause_st_e st_next(input pause_st_e st,
                                          input logic full,
                                          input logic latched);
        pause_st_e n;
        n = st;
        case (st)
            ST_START:  n = ST_WAIT;
            ST_WAIT:   n = full ? ST_PAUSE : ST_WAIT;
            ST_PAUSE:  n = latched ? ST_RESUME : ST_PAUSE;
            ST_RESUME: n = ST_WAIT;
            default:   n = ST_START;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/gen_pause_latch.sv
module gen_pause_latch (
    input  logic clk_i,
    input  logic rst_i,
    input  logic capture_en_i,
    input  logic done_i,
    input  logic ack_i,
    output logic latch_o
);
    logic latch_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            latch_q <= 1'b0;
        end else if (ack_i) begin
            latch_q <= 1'b0;
        end else if (capture_en_i && done_i) begin
            latch_q <= 1'b1;
        end
    end

    assign latch_o = latch_q;
endmodule

// File: rtl/gen_pause_seq.sv
module gen_pause_seq
    import gen_pause_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      full_i,
    input  logic      latch_i,
    output pause_st_e st_o,
    output seq_ctl_t  ctl_o
);
    pause_st_e st_q;
    pause_st_e st_d;

    always_comb begin
        st_d = st_next(st_q, full_i, latch_i);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= ST_START;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ctl_o.pause      = st_pauses(st_q);
        ctl_o.capture_en = (st_q == ST_PAUSE);
        ctl_o.ack        = (st_q == ST_PAUSE) && latch_i;
    end

    assign st_o = st_q;
endmodule

// File: rtl/gen_pause_mask.sv
module gen_pause_mask #(
    parameter int unsigned EN_W   = 32,
    parameter int unsigned LANE_W = 8
) (
    input  logic            pause_i,
    input  logic [EN_W-1:0] glob_i,
    output logic [EN_W-1:0] mod_o,
    output logic [EN_W-1:0] en_o
);
    localparam int unsigned LANES = EN_W / LANE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mod;
        assign lane_mod = {LANE_W{pause_i}};
        assign mod_o[g*LANE_W +: LANE_W] = lane_mod;
        assign en_o[g*LANE_W +: LANE_W]  = glob_i[g*LANE_W +: LANE_W] ^ lane_mod;
    end
endmodule

// File: rtl/gen_pause_ctrl.sv
module gen_pause_ctrl
    import gen_pause_pkg::*;
#(
    parameter int unsigned EN_W   = EN_W_DEF,
    parameter int unsigned LANE_W = LANE_W_DEF
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            buf_full_i,
    input  logic            host_done_i,
    input  logic [EN_W-1:0] glob_en_i,
    output logic [EN_W-1:0] mod_word_o,
    output logic [EN_W-1:0] gen_en_o
);
    pause_st_e st_q;
    seq_ctl_t  ctl;
    logic      latch_q;

    gen_pause_seq u_seq (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .full_i  (buf_full_i),
        .latch_i (latch_q),
        .st_o    (st_q),
        .ctl_o   (ctl)
    );

    gen_pause_latch u_latch (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .capture_en_i (ctl.capture_en),
        .done_i       (host_done_i),
        .ack_i        (ctl.ack),
        .latch_o      (latch_q)
    );

    gen_pause_mask #(.EN_W(EN_W), .LANE_W(LANE_W)) u_mask (
        .pause_i (ctl.pause),
        .glob_i  (glob_en_i),
        .mod_o   (mod_word_o),
        .en_o    (gen_en_o)
    );
endmodule

// File: rtl/gen_pause_ctrl_chk.sv
module gen_pause_ctrl_chk
    import gen_pause_pkg::*;
#(
    parameter int unsigned EN_W = 32
) (
    input logic            clk_i,
    input logic            rst_i,
    input logic            buf_full_i,
    input logic [EN_W-1:0] glob_en_i,
    input logic [EN_W-1:0] mod_word_o,
    input logic [EN_W-1:0] gen_en_o,
    input pause_st_e       st_q,
    input logic            latch_q
);
    a_r1_reset_clears: assert property (@(posedge clk_i)
        rst_i |=> (st_q == ST_START) && (mod_word_o == '0) && !latch_q);

    a_r2_inverted_when_masked: assert property (@(posedge clk_i) disable iff (rst_i)
        (mod_word_o != '0) |-> (gen_en_o == ~glob_en_i) && (mod_word_o == '1));

    a_r2_pass_when_clear: assert property (@(posedge clk_i) disable iff (rst_i)
        (mod_word_o == '0) |-> (gen_en_o == glob_en_i));

    a_r3_start_one_cycle: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == ST_START) |=> (st_q == ST_WAIT));

    a_r4_full_pauses: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == ST_WAIT) && buf_full_i |=> (mod_word_o == '1));

    a_r5_hold_pause: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == ST_PAUSE) && !latch_q |=> (st_q == ST_PAUSE));

    a_r6_ack_clears: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == ST_PAUSE) && latch_q |=> (st_q == ST_RESUME) && !latch_q);

    a_r7_resume_one_cycle: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == ST_RESUME) |=> (st_q == ST_WAIT) && (mod_word_o == '0));

    a_r8_no_capture_outside: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q != ST_PAUSE) && !latch_q |=> !latch_q);

    a_r9_no_restart: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q != ST_START) |=> (st_q != ST_START));
endmodule

bind gen_pause_ctrl gen_pause_ctrl_chk #(.EN_W(EN_W)) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .buf_full_i (buf_full_i),
    .glob_en_i  (glob_en_i),
    .mod_word_o (mod_word_o),
    .gen_en_o   (gen_en_o),
    .st_q       (st_q),
    .latch_q    (latch_q)
);

// File: tb/sim_gen_pause_ctrl.sv
module sim_gen_pause_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        full = 1'b0;
    logic        done = 1'b0;
    logic [31:0] glob = 32'h0;
    logic [31:0] mod_w;
    logic [31:0] gen_en;
    int          n_run = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    gen_pause_ctrl u0 (
        .clk_i       (clk),
        .rst_i       (rst),
        .buf_full_i  (full),
        .host_done_i (done),
        .glob_en_i   (glob),
        .mod_word_o  (mod_w),
        .gen_en_o    (gen_en)
    );

    // {global enable, full, check-done, expected pause after the edge}
    localparam int NV = 18;
    localparam logic [34:0] VEC [NV] = '{
        {32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0},  // R4 waiting
        {32'h1234_5678, 1'b0, 1'b1, 1'b0},  // R8 done while waiting
        {32'hA5A5_A5A5, 1'b1, 1'b0, 1'b1},  // R4 full pauses
        {32'h0F0F_0F0F, 1'b0, 1'b0, 1'b1},  // R8 early done not held
        {32'h8000_0001, 1'b1, 1'b0, 1'b1},  // R5 full while paused
        {32'hDEAD_BEEF, 1'b0, 1'b1, 1'b1},  // R6 latch set
        {32'h0000_0000, 1'b0, 1'b0, 1'b0},  // R6 resume
        {32'hFFFF_0000, 1'b1, 1'b0, 1'b0},  // R7 full in resume
        {32'h0000_FFFF, 1'b0, 1'b0, 1'b0},  // R7 ignored
        {32'h5555_AAAA, 1'b1, 1'b1, 1'b1},  // R8 done with full in wait
        {32'hCAFE_F00D, 1'b0, 1'b0, 1'b1},  // R8 not captured
        {32'h0123_4567, 1'b0, 1'b1, 1'b1},  // R6 latch set
        {32'h89AB_CDEF, 1'b0, 1'b1, 1'b0},  // R6 resume
        {32'h7FFF_FFFE, 1'b0, 1'b1, 1'b0},  // R8 done in resume
        {32'h3C3C_3C3C, 1'b1, 1'b0, 1'b1},  // R9 immediate repause
        {32'hC3C3_C3C3, 1'b0, 1'b1, 1'b1},  // R6 latch set
        {32'h1111_1111, 1'b0, 1'b0, 1'b0},  // R6 resume
        {32'hEEEE_EEEE, 1'b0, 1'b0, 1'b0}   // R9 waiting
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic paused);
        logic [31:0] em;
        logic [31:0] ee;
        em = paused ? 32'hFFFF_FFFF : 32'h0;
        ee = glob ^ em;
        n_run++;
        if (mod_w !== em || gen_en !== ee) begin
            n_fail++;
            $display("FAIL %s: mod=%h en=%h expected mod=%h en=%h", req, mod_w, gen_en, em, ee);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        glob = 32'h6A6A_1234;
        tick(); tick();
        chk("R1 reset", 1'b0);
        rst = 1'b0; full = 1'b1;
        tick();
        chk("R3 start ignores full", 1'b0);
        full = 1'b0;
        tick();
        chk("R3 still running", 1'b0);

        for (int i = 0; i < NV; i++) begin
            glob = VEC[i][34:3];
            full = VEC[i][2];
            done = VEC[i][1];
            tick();
            chk($sformatf("R2 vector %0d", i), VEC[i][0]);
        end

        full = 1'b1; done = 1'b0;
        tick();
        chk("R4 pause before reset", 1'b1);
        full = 1'b0; done = 1'b1;
        tick();
        chk("R6 latch before reset", 1'b1);
        done = 1'b0; rst = 1'b1;
        tick();
        chk("R1 reset mid pause", 1'b0);
        rst = 1'b0;
        tick();
        chk("R3 start after reset", 1'b0);
        full = 1'b1;
        tick();
        chk("R4 pause after reset", 1'b1);
        full = 1'b0;
        for (int k = 0; k < 4; k++) begin
            tick();
            chk("R1 latch cleared by reset", 1'b1);
        end
        done = 1'b1;
        tick();
        chk("R6 latch set", 1'b1);
        done = 1'b0;
        tick();
        chk("R6 resume", 1'b0);
        tick();
        chk("R7 waiting after resume", 1'b0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule